// File: doc/BRIEF.md
# Register Window Pointer Unit

This block keeps the window pointer of a windowed integer register file, together with a window invalid mask and the small set of trap-control and mode bits an integer unit needs around it. Each cycle it may accept one command: step the pointer down (SAVE), step it up (RESTORE), return from a trap, or load a new processor state word. A command either commits its state change or reports exactly one trap with a type code. The state change or the trap shows up in the cycle after the command.

The block always presents the packed processor state word for reads. The word is built from the stored condition flags, the FP-enable bit, the interrupt level, the mode bits and the pointer, with a fixed version field at the top. After a state word write is accepted, the block pulses a request so that the interrupt logic looks again at pending interrupts. The invalid mask is loaded through its own write port.

Top module: `winptr_unit`

## Requirements
- R1: SAVE sets the pointer to (pointer - 1) mod NWIN. RESTORE and a successful return-from-trap set it to (pointer + 1) mod NWIN. NWIN is a parameter from 2 to 32.
- R2: When bit `target` of the invalid mask is set, SAVE raises trap type 8'h05 (window overflow) and leaves all state unchanged. `target` is the pointer value that SAVE would produce.
- R3: When bit `target` of the invalid mask is set, RESTORE or return-from-trap raises trap type 8'h06 (window underflow) and leaves all state unchanged. `target` is the pointer value the command would produce.
- R4: Return-from-trap with the trap-enable bit already 1 raises trap type 8'h02 (illegal instruction) and changes nothing. This test takes priority over the mask test.
- R5: A successful return-from-trap sets the trap-enable bit to 1 and copies the previous-supervisor bit into the supervisor bit.
- R6: A state word write whose bits 4:0 hold a value of NWIN or more raises trap type 8'h02, changes nothing and gives no re-evaluation pulse.
- R7: An accepted state word write loads the flags from bits 23:20, FP-enable from bit 12, the level from bits 11:8, supervisor from bit 7, previous-supervisor from bit 6, trap-enable from bit 5 and the pointer from bits 4:0. All other bits are ignored. `irq_recheck` pulses high for one cycle after the write.
- R8: `state_word` shows the VERSION parameter in bits 31:24, the flags N,Z,V,C in bits 23,22,21,20, FP-enable in bit 12, the level in bits 11:8, supervisor in bit 7, previous-supervisor in bit 6, trap-enable in bit 5 and the pointer in bits 4:0. All remaining bits read 0.
- R9: After reset the pointer is 0, supervisor is 1, every other stored bit is 0, and the invalid mask is 0.
- R10: `trap_valid` and `irq_recheck` are one-cycle pulses in the cycle after a command. They are never high together, and both stay low when no command is given. A mask written through `mask_we` applies from the next command onward. The codes are 00 SAVE, 01 RESTORE, 10 return-from-trap, 11 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | Command code: 00 SAVE, 01 RESTORE, 10 return-from-trap, 11 write state word |
| cmd_data | input | 32 | State word for the write command |
| mask_we | input | 1 | Load the invalid mask |
| mask_wdata | input | 32 | New invalid mask, one bit per window |
| state_word | output | 32 | Packed processor state word |
| wptr | output | 5 | Current window pointer |
| trap_valid | output | 1 | One-cycle trap indication |
| trap_type | output | 8 | Trap type code, meaningful with trap_valid |
| irq_recheck | output | 1 | One-cycle request to re-evaluate interrupts |

## Verification
The bench uses five windows, so the wrap does not come from a natural power-of-two overflow. A design that only relied on bit truncation would step from 4 to 5 instead of back to 0. It places a single invalid bit at every window and starts SAVE, RESTORE and return-from-trap from every pointer. This exposes a mask test made against the current pointer instead of the target one, or a trap that still moves the pointer. Return-from-trap is also run with trap enable set and the target window invalid, which catches a reversed priority that reports underflow. Writes with pointer fields from 5 to 31 must all be refused. Writes with junk in the reserved bits must leave those bits reading zero.

// File: rtl/winptr_pkg.sv
package winptr_pkg;

    localparam int PTR_W = 5;

    typedef enum logic [1:0] {
        OP_SAVE    = 2'd0,
        OP_RESTORE = 2'd1,
        OP_RETT    = 2'd2,
        OP_WRITE   = 2'd3
    } wp_op_e;

    localparam logic [7:0] TT_ILLEGAL = 8'h02;
    localparam logic [7:0] TT_WIN_OVF = 8'h05;
    localparam logic [7:0] TT_WIN_UNF = 8'h06;

    typedef struct packed {
        logic [3:0]       flags;     // N,Z,V,C
        logic             fp_en;
        logic [3:0]       level;
        logic             sup;
        logic             prev_sup;
        logic             trap_en;
        logic [PTR_W-1:0] ptr;
    } wp_state_t;

    localparam wp_state_t WP_RESET = '{flags: 4'h0, fp_en: 1'b0, level: 4'h0,
                                       sup: 1'b1, prev_sup: 1'b0, trap_en: 1'b0,
                                       ptr: '0};

    function automatic wp_state_t word_to_state(input logic [31:0] w);
        wp_state_t s;
        s.flags    = w[23:20];
        s.fp_en    = w[12];
        s.level    = w[11:8];
        s.sup      = w[7];
        s.prev_sup = w[6];
        s.trap_en  = w[5];
        s.ptr      = w[4:0];
        return s;
    endfunction

    function automatic logic [31:0] state_to_word(input wp_state_t s, input logic [7:0] ver);
        return {ver, s.flags, 7'd0, s.fp_en, s.level, s.sup, s.prev_sup, s.trap_en, s.ptr};
    endfunction

endpackage

// File: rtl/wp_step.sv
module wp_step #(
    parameter int NWIN = 8
) (
    input  logic [4:0] cur,
    output logic [4:0] up,
    output logic [4:0] dn
);
    localparam logic [4:0] LAST = 5'(NWIN - 1);

    generate
        if (NWIN == 32) begin : g_pow2
            // Full five-bit range: natural wrap of the adder.
            assign up = cur + 5'd1;
            assign dn = cur - 5'd1;
        end else begin : g_cmp
            assign up = (cur == LAST) ? 5'd0 : cur + 5'd1;
            assign dn = (cur == 5'd0) ? LAST : cur - 5'd1;
        end
    endgenerate
endmodule

// File: rtl/wp_decide.sv
module wp_decide
    import winptr_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [31:0] cmd_data,
    input  wp_state_t   cur,
    input  logic [31:0] inv_mask,
    output wp_state_t   nxt,
    output logic        trap,
    output logic [7:0]  code,
    output logic        recheck
);
    localparam logic [5:0] NW6 = 6'(NWIN);

    logic [4:0] ptr_up, ptr_dn;
    logic       field_ok;
    wp_op_e     op;

    wp_step #(.NWIN(NWIN)) u_step (.cur(cur.ptr), .up(ptr_up), .dn(ptr_dn));

    assign op       = wp_op_e'(cmd_op);
    assign field_ok = ({1'b0, cmd_data[4:0]} < NW6);

    always_comb begin
        nxt     = cur;
        trap    = 1'b0;
        code    = 8'h00;
        recheck = 1'b0;
        if (cmd_valid) begin
            case (op)
                OP_SAVE: begin
                    if (inv_mask[ptr_dn]) begin
                        trap = 1'b1;
                        code = TT_WIN_OVF;
                    end else begin
                        nxt.ptr = ptr_dn;
                    end
                end
                OP_RESTORE: begin
                    if (inv_mask[ptr_up]) begin
                        trap = 1'b1;
                        code = TT_WIN_UNF;
                    end else begin
                        nxt.ptr = ptr_up;
                    end
                end
                OP_RETT: begin
                    if (cur.trap_en) begin
                        trap = 1'b1;
                        code = TT_ILLEGAL;
                    end else if (inv_mask[ptr_up]) begin
                        trap = 1'b1;
                        code = TT_WIN_UNF;
                    end else begin
                        nxt.ptr     = ptr_up;
                        nxt.trap_en = 1'b1;
                        nxt.sup     = cur.prev_sup;
                    end
                end
                default: begin // OP_WRITE
                    if (!field_ok) begin
                        trap = 1'b1;
                        code = TT_ILLEGAL;
                    end else begin
                        nxt     = word_to_state(cmd_data);
                        recheck = 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/wp_pack.sv
module wp_pack
    import winptr_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h10
) (
    input  wp_state_t   st,
    output logic [31:0] word
);
    assign word = state_to_word(st, VERSION);
endmodule

// File: rtl/winptr_unit.sv
module winptr_unit
    import winptr_pkg::*;
#(
    parameter int         NWIN    = 8,
    parameter logic [7:0] VERSION = 8'h10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [31:0] cmd_data,
    input  logic        mask_we,
    input  logic [31:0] mask_wdata,
    output logic [31:0] state_word,
    output logic [4:0]  wptr,
    output logic        trap_valid,
    output logic [7:0]  trap_type,
    output logic        irq_recheck
);
    localparam logic [5:0] NW6 = 6'(NWIN);

    generate
        if (NWIN < 2 || NWIN > 32) begin : g_bad_nwin
            $error("winptr_unit: NWIN must lie in 2..32");
        end
    endgenerate

    wp_state_t   st_q, st_d;
    logic [31:0] mask_q;
    logic        trap_d, rc_d;
    logic [7:0]  code_d;

    wp_decide #(.NWIN(NWIN)) u_decide (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data),
        .cur       (st_q),
        .inv_mask  (mask_q),
        .nxt       (st_d),
        .trap      (trap_d),
        .code      (code_d),
        .recheck   (rc_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= WP_RESET;
            mask_q      <= '0;
            trap_valid  <= 1'b0;
            trap_type   <= 8'h00;
            irq_recheck <= 1'b0;
        end else begin
            st_q        <= st_d;
            trap_valid  <= trap_d;
            trap_type   <= code_d;
            irq_recheck <= rc_d;
            if (mask_we) mask_q <= mask_wdata;
        end
    end

    wp_pack #(.VERSION(VERSION)) u_pack (.st(st_q), .word(state_word));

    assign wptr = st_q.ptr;

    // Pointer always names an existing window (R1).
    p_ptr_range_r1: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, st_q.ptr} < NW6));

    // A trapped command leaves the stored state as it was (R2, R3, R4, R6).
    p_trap_keeps_state_r2: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> (st_q == $past(st_q)));

    // Trap enable only rises through return-from-trap or a write (R5).
    p_te_source_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.trap_en) |-> ($past(cmd_valid) &&
            ($past(cmd_op) == 2'(OP_RETT) || $past(cmd_op) == 2'(OP_WRITE))));

    // Return-from-trap carries the previous mode into the current one (R5).
    p_sup_copy_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(st_q.trap_en) && $past(cmd_op) == 2'(OP_RETT))
            |-> (st_q.sup == $past(st_q.prev_sup)));

    // Trap and re-evaluation request are exclusive (R10).
    p_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(trap_valid && irq_recheck));

    // No command: no pulse and no state change (R10).
    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(cmd_valid) && !$past(rst))
            |-> (!trap_valid && !irq_recheck && st_q == $past(st_q)));
endmodule

// File: tb/sim_winptr_unit.sv
module sim_winptr_unit;
    localparam int         CLK_PERIOD = 10;
    localparam int         NW         = 5;
    localparam logic [7:0] VER        = 8'hA3;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [31:0] cmd_data;
    logic        mask_we;
    logic [31:0] mask_wdata;
    logic [31:0] state_word;
    logic [4:0]  wptr;
    logic        trap_valid;
    logic [7:0]  trap_type;
    logic        irq_recheck;

    int n_chk = 0;
    int n_err = 0;

    // Bench model of stored state
    logic [3:0]  m_flags;
    logic        m_fp, m_s, m_ps, m_et;
    logic [3:0]  m_lvl;
    logic [4:0]  m_ptr;
    logic [31:0] m_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    winptr_unit #(.NWIN(NW), .VERSION(VER)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .state_word(state_word), .wptr(wptr), .trap_valid(trap_valid),
        .trap_type(trap_type), .irq_recheck(irq_recheck)
    );

    function automatic logic [31:0] exp_word();
        return {VER, m_flags, 7'd0, m_fp, m_lvl, m_s, m_ps, m_et, m_ptr};
    endfunction

    function automatic logic [31:0] mk(input logic [3:0] fl, input logic fp,
                                       input logic [3:0] lv, input logic s,
                                       input logic ps, input logic et,
                                       input logic [4:0] p);
        // junk in reserved and version bits must be ignored (R7)
        return {8'h5A, fl, 7'h55, fp, lv, s, ps, et, p};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic load_mask(input logic [31:0] v);
        mask_we = 1'b1; mask_wdata = v;
        @(posedge clk); @(negedge clk);
        mask_we = 1'b0;
        m_mask = v;
    endtask

    task automatic run(input logic [1:0] op, input logic [31:0] data, input string tag);
        logic [4:0]  up, dn;
        logic        etrap, erc;
        logic [7:0]  ecode;
        logic [46:0] a, e;
        up = (m_ptr == 5'(NW - 1)) ? 5'd0 : m_ptr + 5'd1;
        dn = (m_ptr == 5'd0) ? 5'(NW - 1) : m_ptr - 5'd1;
        etrap = 1'b0; erc = 1'b0; ecode = 8'h00;
        case (op)
            2'd0: if (m_mask[dn]) begin etrap = 1'b1; ecode = 8'h05; end
                  else m_ptr = dn;
            2'd1: if (m_mask[up]) begin etrap = 1'b1; ecode = 8'h06; end
                  else m_ptr = up;
            2'd2: if (m_et) begin etrap = 1'b1; ecode = 8'h02; end
                  else if (m_mask[up]) begin etrap = 1'b1; ecode = 8'h06; end
                  else begin m_ptr = up; m_et = 1'b1; m_s = m_ps; end
            default:
                if (data[4:0] >= 5'(NW)) begin etrap = 1'b1; ecode = 8'h02; end
                else begin
                    m_flags = data[23:20]; m_fp = data[12]; m_lvl = data[11:8];
                    m_s = data[7]; m_ps = data[6]; m_et = data[5];
                    m_ptr = data[4:0]; erc = 1'b1;
                end
        endcase
        cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        a = {trap_valid, trap_type, irq_recheck, state_word, wptr};
        e = {etrap, ecode, erc, exp_word(), m_ptr};
        check(a == e, tag, 64'(a), 64'(e));
        @(posedge clk); @(negedge clk);
        a = {trap_valid, trap_type & 8'h00, irq_recheck, state_word, wptr};
        e = {1'b0, 8'h00, 1'b0, exp_word(), m_ptr};
        check(a == e, "R10 idle after command", 64'(a), 64'(e));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R10 watchdog: actual=hang expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_data = '0;
        mask_we = 1'b0; mask_wdata = '0;
        m_flags = '0; m_fp = 1'b0; m_lvl = '0; m_s = 1'b1; m_ps = 1'b0;
        m_et = 1'b0; m_ptr = '0; m_mask = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R9 reset state
        check({trap_valid, irq_recheck, state_word} == {2'b00, VER, 24'h000080},
              "R9 reset", 64'({trap_valid, irq_recheck, state_word}),
              64'({2'b00, VER, 24'h000080}));

        // R1 wrap in both directions with an empty mask
        for (int i = 0; i < NW + 2; i++) run(2'd0, 32'h0, "R1 save step");
        for (int i = 0; i < NW + 2; i++) run(2'd1, 32'h0, "R1 restore step");

        // R2/R3/R5 single invalid window at every place, every start pointer
        for (int w = 0; w < NW; w++) begin
            load_mask(32'h1 << w);
            for (int c = 0; c < NW; c++) begin
                run(2'd3, mk(4'(c), 1'b0, 4'(w), 1'b1, 1'b0, 1'b0, 5'(c)), "R7 write");
                run(2'd0, 32'h0, "R2 save vs mask");
                run(2'd3, mk(4'(w), 1'b1, 4'(c), 1'b0, 1'b1, 1'b0, 5'(c)), "R7 write");
                run(2'd1, 32'h0, "R3 restore vs mask");
                run(2'd3, mk(4'hF, 1'b0, 4'h0, ~c[0], c[0], 1'b0, 5'(c)), "R7 write");
                run(2'd2, 32'h0, "R3 R5 return-from-trap");
            end
        end

        // R4 illegal takes priority over the mask test
        load_mask(32'hFFFF_FFFF);
        run(2'd3, mk(4'h3, 1'b0, 4'h7, 1'b0, 1'b1, 1'b1, 5'd2), "R7 write");
        run(2'd2, 32'h0, "R4 trap enable set, window invalid");
        load_mask(32'h0);
        run(2'd2, 32'h0, "R4 trap enable set, window valid");

        // R6 pointer field out of range
        for (int v = NW; v < 32; v++) run(2'd3, mk(4'h9, 1'b1, 4'hA, 1'b1, 1'b1, 1'b0, 5'(v)), "R6 bad pointer field");

        // R8 packing under varied field patterns
        for (int k = 0; k < 16; k++)
            run(2'd3, mk(4'(k), k[0], ~4'(k), k[1], k[2], k[3], 5'(k % NW)), "R8 pack");

        // R10 mask bits above the window count have no effect
        load_mask(32'hFFFF_FFE0);
        run(2'd3, mk(4'h0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 5'd0), "R7 write");
        for (int i = 0; i < NW + 1; i++) run(2'd0, 32'h0, "R10 upper mask bits ignored");
        for (int i = 0; i < NW + 1; i++) run(2'd1, 32'h0, "R10 upper mask bits ignored");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule